// File: doc/BRIEF.md
# Machine Status and Trap-Control Register Write Path

This block holds the privileged status word, the interrupt-enable word, the interrupt and exception delegation words and the two trap-vector base registers of a small hart. The execute stage drives a 12-bit register address, write data and a write strobe. The block filters each write through a field mask chosen by the target register. An unsupported previous-privilege encoding is dropped without any error. The summary dirty bit is computed again on every status write. A one-cycle flush request goes to the address-translation logic when a write touches a field that affects translation.

Two supervisor addresses do not have storage of their own. The supervisor status view and the supervisor interrupt-enable view read and write the machine registers through narrower masks. A combinational read port returns the masked value of the addressed register in the same cycle.

Top module: `mcsr_status_wr`

## Requirements
- R1: After the asynchronous reset (rst_ni low), all six stored registers are zero and flush_o is low.
- R2: A write to the machine status register (address 0x300) changes only bits 1, 3, 5, 7, 8, 12:11 (previous privilege), 14:13 (FS), 17, 18 and 19. Every other bit keeps its value, and bits 16:15 (XS) are never changed by this block.
- R3: If the written bits 12:11 hold 2'b01 while HAS_S is 0, or 2'b00 while HAS_U is 0, bits 12:11 keep their old value and the other writable fields of the same write still update.
- R4: After every status write, bit XLEN-1 is 1 when bits 14:13 equal 2'b11 or bits 16:15 equal 2'b11, and 0 otherwise.
- R5: flush_o is high for exactly the one cycle after a status write (address 0x300 or 0x100) whose written value differs from the old status value in bits 12:11, 17, 18 or 19. The written value is compared before the previous-privilege filter. No other write raises flush_o.
- R6: The interrupt-enable register (0x304) accepts only bits 1, 3, 5, 7 and 9. The interrupt-delegation register (0x303) accepts only bits 1, 5 and 9.
- R7: The exception-delegation register (0x302) accepts only bits 0 to 13 and bit 15. All other bits read as zero.
- R8: A write to the supervisor status view (0x100) first merges the write data into bits 0, 1, 4, 5, 8, 14:13, 16:15, 18, 19 and XLEN-1 of the current status value, then passes the result through the machine status write path. A read of 0x100 returns the status value ANDed with that same bit set.
- R9: A write to the supervisor interrupt-enable view (0x104) changes only the enable bits that are set in the interrupt-delegation register. A read of 0x104 returns the enable register ANDed with the delegation register.
- R10: A write to a trap-vector register (machine 0x305, supervisor 0x105) with data bit 0 set is ignored. Otherwise the register stores the data with bits 1:0 forced to zero.
- R11: Reads of any unmapped address return zero, and writes to an unmapped address change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; writes take effect on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| we_i | input | 1 | Write strobe |
| addr_i | input | 12 | Register address for the read and the write |
| wdata_i | input | XLEN | Write data |
| rdata_o | output | XLEN | Masked value of the addressed register, combinational |
| flush_o | output | 1 | One-cycle translation flush request |

## Verification
The hardest case is a status write whose previous-privilege field is rejected but still differs from the stored value. The field stays put, while the flush still fires and the rest of the word updates. The bench builds this case with HAS_S set to 0. It first loads the field with machine mode, then writes supervisor mode together with cleared neighbouring fields. The supervisor interrupt view is driven under two different delegation settings, so both the masked-off bits and the delegated bits of the enable register are seen to behave correctly.

// File: rtl/mcsr_status_pkg.sv
package mcsr_status_pkg;
  localparam int unsigned ADDR_W = 12;

  localparam logic [ADDR_W-1:0] A_M_STATUS = 12'h300;
  localparam logic [ADDR_W-1:0] A_EXC_DELEG = 12'h302;
  localparam logic [ADDR_W-1:0] A_IRQ_DELEG = 12'h303;
  localparam logic [ADDR_W-1:0] A_M_IE = 12'h304;
  localparam logic [ADDR_W-1:0] A_M_TVEC = 12'h305;
  localparam logic [ADDR_W-1:0] A_S_STATUS = 12'h100;
  localparam logic [ADDR_W-1:0] A_S_IE = 12'h104;
  localparam logic [ADDR_W-1:0] A_S_TVEC = 12'h105;

  localparam int unsigned PP_LO = 11;
  localparam int unsigned FS_LO = 13;
  localparam int unsigned XS_LO = 15;

  // low-word masks; the summary bit sits at XLEN-1 and is added by the user
  localparam logic [31:0] ST_WR_LO = 32'h000E_79AA;
  localparam logic [31:0] ST_FLUSH_LO = 32'h000E_1800;
  localparam logic [31:0] SV_VIEW_LO = 32'h000D_E133;
  localparam logic [31:0] PP_LO_MASK = 32'h0000_1800;
  localparam logic [31:0] IE_LO = 32'h0000_02AA;
  localparam logic [31:0] IRQ_DLG_LO = 32'h0000_0222;
  localparam logic [31:0] EXC_DLG_LO = 32'h0000_BFFF;

  localparam logic [1:0] PP_USER = 2'b00;
  localparam logic [1:0] PP_SUP = 2'b01;
endpackage

// File: rtl/mcsr_status_next.sv
module mcsr_status_next
  import mcsr_status_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter bit HAS_S = 1'b1,
  parameter bit HAS_U = 1'b1
) (
  input  logic [XLEN-1:0] cur_i,
  input  logic [XLEN-1:0] cand_i,
  output logic [XLEN-1:0] next_o,
  output logic            chg_o
);
  localparam logic [XLEN-1:0] WR_MASK = XLEN'(ST_WR_LO);
  localparam logic [XLEN-1:0] PP_MASK = XLEN'(PP_LO_MASK);
  localparam logic [XLEN-1:0] FL_MASK = XLEN'(ST_FLUSH_LO);

  logic [1:0]      pp_req;
  logic            pp_bad;
  logic [XLEN-1:0] eff_mask;
  logic [XLEN-1:0] merged;
  logic            dirty;

  always_comb begin
    pp_req   = cand_i[PP_LO +: 2];
    pp_bad   = (!HAS_S && pp_req == PP_SUP) || (!HAS_U && pp_req == PP_USER);
    eff_mask = pp_bad ? (WR_MASK & ~PP_MASK) : WR_MASK;
    merged   = (cur_i & ~eff_mask) | (cand_i & eff_mask);
    dirty    = (&merged[FS_LO +: 2]) | (&merged[XS_LO +: 2]);
    next_o   = {dirty, merged[XLEN-2:0]};
    // compared against the raw written word, before privilege filtering
    chg_o    = |((cand_i ^ cur_i) & FL_MASK);
  end
endmodule

// File: rtl/mcsr_mask_reg.sv
module mcsr_mask_reg
  import mcsr_status_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter logic [ADDR_W-1:0] ADDR = 12'h000,
  parameter logic [XLEN-1:0] MASK = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [XLEN-1:0]   wdata_i,
  output logic [XLEN-1:0]   q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else if (we_i && addr_i == ADDR) q_o <= (q_o & ~MASK) | (wdata_i & MASK);
  end
endmodule

// File: rtl/mcsr_tvec_reg.sv
module mcsr_tvec_reg
  import mcsr_status_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter logic [ADDR_W-1:0] ADDR = 12'h000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [XLEN-1:0]   wdata_i,
  output logic [XLEN-1:0]   q_o
);
  // vectored mode (bit 0) unsupported: such writes are dropped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else if (we_i && addr_i == ADDR && !wdata_i[0]) q_o <= {wdata_i[XLEN-1:2], 2'b00};
  end
endmodule

// File: rtl/mcsr_status_wr.sv
module mcsr_status_wr
  import mcsr_status_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter bit HAS_S = 1'b1,
  parameter bit HAS_U = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [XLEN-1:0]   wdata_i,
  output logic [XLEN-1:0]   rdata_o,
  output logic              flush_o
);
  localparam logic [XLEN-1:0] SUM_BIT = {1'b1, {(XLEN-1){1'b0}}};
  localparam logic [XLEN-1:0] SV_MASK = XLEN'(SV_VIEW_LO) | SUM_BIT;
  localparam logic [XLEN-1:0] IE_MASK = XLEN'(IE_LO);

  logic [XLEN-1:0] status_q, status_cand, status_next;
  logic [XLEN-1:0] ie_q, irq_dlg_q, exc_dlg_q, mtvec_q, stvec_q;
  logic            status_we, status_chg, flush_q;

  always_comb begin
    status_we   = we_i && (addr_i == A_M_STATUS || addr_i == A_S_STATUS);
    status_cand = (addr_i == A_S_STATUS) ? ((status_q & ~SV_MASK) | (wdata_i & SV_MASK))
                                         : wdata_i;
  end

  mcsr_status_next #(.XLEN(XLEN), .HAS_S(HAS_S), .HAS_U(HAS_U)) u_next (
    .cur_i (status_q),
    .cand_i(status_cand),
    .next_o(status_next),
    .chg_o (status_chg)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      flush_q  <= 1'b0;
    end else begin
      if (status_we) status_q <= status_next;
      flush_q <= status_we && status_chg;
    end
  end

  // enable word: full-mask machine path or delegated-only supervisor path
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ie_q <= '0;
    else if (we_i && addr_i == A_M_IE) ie_q <= (ie_q & ~IE_MASK) | (wdata_i & IE_MASK);
    else if (we_i && addr_i == A_S_IE)
      ie_q <= (ie_q & ~(irq_dlg_q & IE_MASK)) | (wdata_i & irq_dlg_q & IE_MASK);
  end

  mcsr_mask_reg #(.XLEN(XLEN), .ADDR(A_IRQ_DELEG), .MASK(XLEN'(IRQ_DLG_LO))) u_irq_dlg (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i, .q_o(irq_dlg_q)
  );

  mcsr_mask_reg #(.XLEN(XLEN), .ADDR(A_EXC_DELEG), .MASK(XLEN'(EXC_DLG_LO))) u_exc_dlg (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i, .q_o(exc_dlg_q)
  );

  mcsr_tvec_reg #(.XLEN(XLEN), .ADDR(A_M_TVEC)) u_mtvec (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i, .q_o(mtvec_q)
  );

  mcsr_tvec_reg #(.XLEN(XLEN), .ADDR(A_S_TVEC)) u_stvec (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i, .q_o(stvec_q)
  );

  always_comb begin
    unique case (addr_i)
      A_M_STATUS:  rdata_o = status_q;
      A_S_STATUS:  rdata_o = status_q & SV_MASK;
      A_M_IE:      rdata_o = ie_q;
      A_S_IE:      rdata_o = ie_q & irq_dlg_q;
      A_IRQ_DELEG: rdata_o = irq_dlg_q;
      A_EXC_DELEG: rdata_o = exc_dlg_q;
      A_M_TVEC:    rdata_o = mtvec_q;
      A_S_TVEC:    rdata_o = stvec_q;
      default:     rdata_o = '0;
    endcase
  end

  assign flush_o = flush_q;
endmodule

// File: rtl/mcsr_status_wr_chk.sv
module mcsr_status_wr_chk
  import mcsr_status_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [XLEN-1:0]   wdata_i,
  input logic [XLEN-1:0]   rdata_o,
  input logic              flush_o,
  input logic [XLEN-1:0]   mtvec_q
);
  localparam logic [XLEN-1:0] IRQ_M = XLEN'(IRQ_DLG_LO);
  localparam logic [XLEN-1:0] EXC_M = XLEN'(EXC_DLG_LO);

  assert_sd_summary_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i == A_M_STATUS |->
      rdata_o[XLEN-1] == ((&rdata_o[FS_LO +: 2]) | (&rdata_o[XS_LO +: 2])));

  assert_flush_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> $past(we_i) && ($past(addr_i) == A_M_STATUS || $past(addr_i) == A_S_STATUS));

  assert_irq_deleg_mask_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i == A_IRQ_DELEG |-> (rdata_o & ~IRQ_M) == '0);

  assert_exc_deleg_mask_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i == A_EXC_DELEG |-> (rdata_o & ~EXC_M) == '0);

  assert_sie_subset_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i == A_S_IE |-> (rdata_o & ~IRQ_M) == '0);

  assert_tvec_odd_drop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_M_TVEC && wdata_i[0]) |=> $stable(mtvec_q));

  assert_tvec_align_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mtvec_q[1:0] == 2'b00);
endmodule

bind mcsr_status_wr mcsr_status_wr_chk #(.XLEN(XLEN)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .we_i   (we_i),
  .addr_i (addr_i),
  .wdata_i(wdata_i),
  .rdata_o(rdata_o),
  .flush_o(flush_o),
  .mtvec_q(mtvec_q)
);

// File: tb/mcsr_status_wr_tb_top.sv
module mcsr_status_wr_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 32;
  localparam bit HAS_S = 1'b0;
  localparam bit HAS_U = 1'b1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [11:0] addr = 12'h000;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        flush;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mcsr_status_wr #(.XLEN(XLEN), .HAS_S(HAS_S), .HAS_U(HAS_U)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .flush_o(flush)
  );

  // reference state
  logic [31:0] m_st, m_ie, m_idl, m_edl, m_mtv, m_stv;
  logic        m_fl;

  function automatic logic [31:0] st_apply(input logic [31:0] cur, input logic [31:0] v);
    logic [31:0] r;
    int pp;
    r = cur;
    r[1] = v[1]; r[3] = v[3]; r[5] = v[5]; r[7] = v[7]; r[8] = v[8];
    r[14:13] = v[14:13]; r[17] = v[17]; r[18] = v[18]; r[19] = v[19];
    pp = int'(v[12:11]);
    if (!((pp == 1 && !HAS_S) || (pp == 0 && !HAS_U))) r[12:11] = v[12:11];
    r[31] = (r[14:13] == 2'b11) || (r[16:15] == 2'b11);
    return r;
  endfunction

  function automatic logic [31:0] sv_merge(input logic [31:0] cur, input logic [31:0] v);
    logic [31:0] r;
    r = cur;
    foreach (r[i]) if (i == 0 || i == 1 || i == 4 || i == 5 || i == 8 || i == 13 || i == 14 ||
                       i == 15 || i == 16 || i == 18 || i == 19 || i == 31) r[i] = v[i];
    return r;
  endfunction

  function automatic bit flush_need(input logic [31:0] cur, input logic [31:0] v);
    return (cur[12:11] != v[12:11]) || (cur[17] != v[17]) || (cur[18] != v[18]) || (cur[19] != v[19]);
  endfunction

  function automatic logic [31:0] ref_read(input logic [11:0] a);
    case (a)
      12'h300: return m_st;
      12'h100: return sv_merge(32'h0, m_st);
      12'h304: return m_ie;
      12'h104: return m_ie & m_idl;
      12'h303: return m_idl;
      12'h302: return m_edl;
      12'h305: return m_mtv;
      12'h105: return m_stv;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string req_of(input logic [11:0] a);
    case (a)
      12'h300: return "R2";
      12'h100: return "R8";
      12'h304, 12'h303: return "R6";
      12'h104: return "R9";
      12'h302: return "R7";
      12'h305, 12'h105: return "R10";
      default: return "R11";
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st <= '0; m_ie <= '0; m_idl <= '0; m_edl <= '0; m_mtv <= '0; m_stv <= '0; m_fl <= 1'b0;
    end else begin
      logic [31:0] cand;
      m_fl <= 1'b0;
      if (we) begin
        case (addr)
          12'h300, 12'h100: begin
            cand = (addr == 12'h100) ? sv_merge(m_st, wdata) : wdata;
            m_st <= st_apply(m_st, cand);
            m_fl <= flush_need(m_st, cand);
          end
          12'h304: m_ie <= wdata & 32'h2AA;
          12'h104: m_ie <= (m_ie & ~m_idl) | (wdata & m_idl);
          12'h303: m_idl <= wdata & 32'h222;
          12'h302: m_edl <= wdata & 32'hBFFF;
          12'h305: if (!wdata[0]) m_mtv <= wdata & ~32'h3;
          12'h105: if (!wdata[0]) m_stv <= wdata & ~32'h3;
          default: ;
        endcase
      end
    end
  end

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // per-clock comparison against the reference
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (rst_n && !done) begin
      check(req_of(addr), rdata, ref_read(addr));
      check("R5", {31'b0, flush}, {31'b0, m_fl});
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; addr = 12'h7C0; wdata = '0;
  endtask

  task automatic rd(input string req, input logic [11:0] a, input logic [31:0] exp);
    @(negedge clk);
    addr = a;
    #1;
    check(req, rdata, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values
    rd("R1", 12'h300, 32'h0);
    rd("R1", 12'h304, 32'h0);
    rd("R1", 12'h302, 32'h0);
    rd("R1", 12'h305, 32'h0);
    check("R1", {31'b0, flush}, 32'h0);

    // R2 R4 R5: all-ones status write
    @(negedge clk); we = 1'b1; addr = 12'h300; wdata = 32'hFFFF_FFFF;
    @(negedge clk); we = 1'b0;
    check("R5", {31'b0, flush}, 32'h1);
    check("R2", rdata, 32'h800E_79AA);
    @(negedge clk);
    check("R5", {31'b0, flush}, 32'h0);
    // R5: identical rewrite raises no flush
    @(negedge clk); we = 1'b1; addr = 12'h300; wdata = 32'hFFFF_FFFF;
    @(negedge clk); we = 1'b0;
    check("R5", {31'b0, flush}, 32'h0);

    // R3: supervisor previous-privilege rejected, others still update, flush still fires
    @(negedge clk); we = 1'b1; addr = 12'h300; wdata = 32'h0000_0800;
    @(negedge clk); we = 1'b0;
    check("R5", {31'b0, flush}, 32'h1);
    check("R3", rdata, 32'h0000_1800);
    wr(12'h300, 32'h0);
    rd("R3", 12'h300, 32'h0);
    // R4: FS partial, summary clear
    wr(12'h300, 32'h0000_2000);
    rd("R4", 12'h300, 32'h0000_2000);

    // R8 supervisor status view
    wr(12'h100, 32'hFFFF_FFFF);
    rd("R8", 12'h300, 32'h800C_6122);
    rd("R8", 12'h100, 32'h800C_6122);

    // R6 R7 masks
    wr(12'h304, 32'hFFFF_FFFF);
    rd("R6", 12'h304, 32'h0000_02AA);
    wr(12'h303, 32'hFFFF_FFFF);
    rd("R6", 12'h303, 32'h0000_0222);
    wr(12'h302, 32'hFFFF_FFFF);
    rd("R7", 12'h302, 32'h0000_BFFF);

    // R9 supervisor enable view under two delegation settings
    wr(12'h104, 32'h0);
    rd("R9", 12'h304, 32'h0000_0088);
    rd("R9", 12'h104, 32'h0);
    wr(12'h303, 32'h0000_0020);
    wr(12'h104, 32'hFFFF_FFFF);
    rd("R9", 12'h304, 32'h0000_00A8);
    rd("R9", 12'h104, 32'h0000_0020);

    // R10 trap vectors
    wr(12'h305, 32'h0000_1235);
    rd("R10", 12'h305, 32'h0);
    wr(12'h305, 32'h0000_1236);
    rd("R10", 12'h305, 32'h0000_1234);
    wr(12'h105, 32'hABCD_0003);
    rd("R10", 12'h105, 32'h0);
    wr(12'h105, 32'hABCD_0002);
    rd("R10", 12'h105, 32'hABCD_0000);
    wr(12'h305, 32'hFFFF_FFFF);
    rd("R10", 12'h305, 32'h0000_1234);

    // R11 unmapped
    wr(12'h7C0, 32'hFFFF_FFFF);
    rd("R11", 12'h7C0, 32'h0);
    rd("R11", 12'h300, 32'h800C_6122);
    rd("R11", 12'h302, 32'h0000_BFFF);

    // R1 again: asynchronous reset mid-run
    @(negedge clk); rst_n = 1'b0;
    #1;
    rd("R1", 12'h300, 32'h0);
    rd("R1", 12'h105, 32'h0);
    @(negedge clk); rst_n = 1'b1;

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule